// File: doc/BRIEF.md
# Dual-Notch Digital Blocker Cancellation Path

This block is the digital feedback path of one channel of a delta-sigma receiver baseband. On every clock it takes the multi-level quantizer code (0 to 16), re-centres it to a signed sample and feeds two programmable second-order IIR bandpass sections in parallel. One section is meant to sit on the fixed transmitter-leakage offset. The other is retuned by an external tuning loop to follow one more blocker anywhere in the range that loop supports.

The two section outputs are added. A first-order digital lowpass stage then undoes the passive first-order highpass that sits at the DAC output. A first-order error-feedback requantizer reduces the result to a signed 5-bit code for the cancellation DAC. Coefficients are written into a staging bank through an address/data/strobe port. They become active all at once on a load pulse, so no filter sees a mix of old and new values within one sample. Each section has its own enable. With both sections off, the whole path is idle and drives zero.

Top module: `dual_notch_path`

## Requirements
- R1: After a synchronous reset, dac_code is 0 and every active coefficient is 0, so enabled sections produce zero output until coefficients are loaded.
- R2: The input code is mapped to a signed sample x = code_in − 8, so code 8 is zero, code 16 is +8 and code 0 is −8.
- R3: Each section computes y = sat18((b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2) >>> 7), where the shift is arithmetic (floor), the coefficients are signed 9-bit Q1.7 and sat18 clamps to −131072..131071. The result is registered as y1, and the earlier y1 moves to y2.
- R4: The outputs of both sections are added into one sum that feeds the lowpass stage.
- R5: A write with cfg_we high stores cfg_data in staging register cfg_addr. Addresses 0–4 hold b0, b1, b2, a1, a2 of the leakage section, 5–9 hold the same five of the tracking section, and 10 holds the lowpass coefficient k. Writes to addresses 11–15 have no effect.
- R6: Staged coefficients become active only on a cycle with cfg_load high, all at the same edge. A write and a load in the same cycle load the value staged before that write.
- R7: The lowpass stage registers z = sat18(sum + ((k·z_prev) >>> 7)).
- R8: The requantizer forms w = z + e_prev and q = clamp(w >>> 2, −16, +15). It stores e = sat18(w − 4·q) and registers q on dac_code as a two's-complement 5-bit value.
- R9: A disabled section outputs zero and has its delay line cleared, so on re-enable it starts from zero state.
- R10: When both sections are disabled at a clock edge, the lowpass state, the requantizer error and dac_code are cleared at that edge.
- R11: A code sampled at edge n first affects dac_code after edge n+2, through the section register, the lowpass register and the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 5 | Quantizer code, 0 to 16 |
| en_tx | input | 1 | Enable of the leakage section |
| en_bl | input | 1 | Enable of the tracking section |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Staging register address |
| cfg_data | input | 9 | Coefficient value, signed Q1.7 |
| cfg_load | input | 1 | Transfer all staged coefficients to the active set |
| dac_code | output | 5 | Signed code for the cancellation DAC |

## Verification
The bench follows the path's fixed-point arithmetic with its own cycle model and goes after the places where that arithmetic is easy to get wrong. It runs a section set up as an integrator for thousands of cycles, so that a missing 18-bit clamp shows up as a wrap to a large negative code. It drives the requantizer into both rails and counts the clock edges of an impulse, which exposes a missing or extra pipeline register. It also checks the error bound between the rails. Other tests toggle one section off while the other stays on, write without loading, and write to unused addresses. A design that kept stale state, applied a coefficient early or aliased the unused addresses would then give a DAC sequence that differs from the model.

// File: rtl/dnp_pkg.sv
package dnp_pkg;
  localparam int NSEC = 2;   // leakage section, tracking section
  localparam int TAPS = 5;   // b0 b1 b2 a1 a2
  localparam int NREG = NSEC * TAPS + 1;  // plus lowpass coefficient
endpackage

// File: rtl/dnp_coef_bank.sv
module dnp_coef_bank #(
  parameter int NREG   = 11,
  parameter int COEF_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [COEF_W-1:0]        wdata,
  input  logic                     load,
  output logic [NREG*COEF_W-1:0]   act_flat
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NREG - 1);

  logic [COEF_W-1:0] staged [NREG];
  logic [COEF_W-1:0] active [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        staged[i] <= '0;
        active[i] <= '0;
      end
    end else begin
      if (load) begin
        for (int i = 0; i < NREG; i++) active[i] <= staged[i];
      end
      if (we && addr <= LAST) staged[addr] <= wdata;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign act_flat[g*COEF_W +: COEF_W] = active[g];
  end
endmodule

// File: rtl/dnp_biquad.sv
module dnp_biquad #(
  parameter int XW      = 6,
  parameter int COEF_W  = 9,
  parameter int FRAC    = 7,
  parameter int STATE_W = 18
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic signed [XW-1:0]        x,
  input  logic [5*COEF_W-1:0]         coef,
  output logic signed [STATE_W-1:0]   y
);
  localparam int ACC_W = STATE_W + COEF_W + 4;
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'(2**(STATE_W-1) - 1);
  localparam logic signed [ACC_W-1:0] SMIN = ACC_W'(-(2**(STATE_W-1)));

  logic signed [COEF_W-1:0]  c [5];
  logic signed [XW-1:0]      x1, x2;
  logic signed [STATE_W-1:0] y2, ynext;
  logic signed [ACC_W-1:0]   acc, shf;

  for (genvar t = 0; t < 5; t++) begin : g_coef
    assign c[t] = coef[t*COEF_W +: COEF_W];
  end

  always_comb begin
    acc = ACC_W'(c[0]) * ACC_W'(x)
        + ACC_W'(c[1]) * ACC_W'(x1)
        + ACC_W'(c[2]) * ACC_W'(x2)
        - ACC_W'(c[3]) * ACC_W'(y)
        - ACC_W'(c[4]) * ACC_W'(y2);
    shf = acc >>> FRAC;
    if (shf > SMAX)      ynext = SMAX[STATE_W-1:0];
    else if (shf < SMIN) ynext = SMIN[STATE_W-1:0];
    else                 ynext = shf[STATE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      x1 <= '0;
      x2 <= '0;
      y  <= '0;
      y2 <= '0;
    end else begin
      x1 <= x;
      x2 <= x1;
      y2 <= y;
      y  <= ynext;
    end
  end
endmodule

// File: rtl/dnp_lowpass.sv
module dnp_lowpass #(
  parameter int COEF_W  = 9,
  parameter int FRAC    = 7,
  parameter int STATE_W = 18
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic signed [STATE_W:0]     s,
  input  logic signed [COEF_W-1:0]    k,
  output logic signed [STATE_W-1:0]   z
);
  localparam int ACC_W = STATE_W + COEF_W + 3;
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'(2**(STATE_W-1) - 1);
  localparam logic signed [ACC_W-1:0] SMIN = ACC_W'(-(2**(STATE_W-1)));

  logic signed [ACC_W-1:0]   prod, acc;
  logic signed [STATE_W-1:0] znext;

  always_comb begin
    prod = ACC_W'(k) * ACC_W'(z);
    acc  = ACC_W'(s) + (prod >>> FRAC);
    if (acc > SMAX)      znext = SMAX[STATE_W-1:0];
    else if (acc < SMIN) znext = SMIN[STATE_W-1:0];
    else                 znext = acc[STATE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) z <= '0;
    else            z <= znext;
  end
endmodule

// File: rtl/dnp_requant.sv
module dnp_requant #(
  parameter int STATE_W = 18,
  parameter int OUT_W   = 5,
  parameter int QSHIFT  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic signed [STATE_W-1:0]   z,
  output logic signed [OUT_W-1:0]     q,
  output logic signed [STATE_W-1:0]   err
);
  localparam int WW = STATE_W + 2;
  localparam logic signed [WW-1:0] QMAX = WW'(2**(OUT_W-1) - 1);
  localparam logic signed [WW-1:0] QMIN = WW'(-(2**(OUT_W-1)));
  localparam logic signed [WW-1:0] EMAX = WW'(2**(STATE_W-1) - 1);
  localparam logic signed [WW-1:0] EMIN = WW'(-(2**(STATE_W-1)));

  logic signed [WW-1:0]      w, qraw, qclip, resid;
  logic signed [OUT_W-1:0]   qnext;
  logic signed [STATE_W-1:0] enext;

  always_comb begin
    w    = WW'(z) + WW'(err);
    qraw = w >>> QSHIFT;
    if (qraw > QMAX)      qclip = QMAX;
    else if (qraw < QMIN) qclip = QMIN;
    else                  qclip = qraw;
    qnext = qclip[OUT_W-1:0];
    resid = w - (qclip <<< QSHIFT);
    if (resid > EMAX)      enext = EMAX[STATE_W-1:0];
    else if (resid < EMIN) enext = EMIN[STATE_W-1:0];
    else                   enext = resid[STATE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q   <= '0;
      err <= '0;
    end else begin
      q   <= qnext;
      err <= enext;
    end
  end
endmodule

// File: rtl/dual_notch_path.sv
module dual_notch_path #(
  parameter int CODE_W  = 5,
  parameter int MID     = 8,
  parameter int COEF_W  = 9,
  parameter int FRAC    = 7,
  parameter int STATE_W = 18,
  parameter int OUT_W   = 5,
  parameter int QSHIFT  = 2,
  parameter int ADDR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CODE_W-1:0]          code_in,
  input  logic                       en_tx,
  input  logic                       en_bl,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [COEF_W-1:0]          cfg_data,
  input  logic                       cfg_load,
  output logic signed [OUT_W-1:0]    dac_code
);
  import dnp_pkg::*;

  localparam int XW    = CODE_W + 1;
  localparam int SEC_W = TAPS * COEF_W;

  logic [NREG*COEF_W-1:0]    act_flat;
  logic signed [XW-1:0]      x_s;
  logic [NSEC-1:0]           en_vec;
  logic signed [STATE_W-1:0] ysec [NSEC];
  logic signed [STATE_W:0]   sum;
  logic signed [STATE_W-1:0] z_lp;
  logic signed [STATE_W-1:0] err_q;
  logic                      path_on;

  assign x_s     = $signed({1'b0, code_in}) - XW'(MID);
  assign en_vec  = {en_bl, en_tx};
  assign path_on = |en_vec;

  dnp_coef_bank #(.NREG(NREG), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_data),
    .load(cfg_load), .act_flat(act_flat)
  );

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    dnp_biquad #(.XW(XW), .COEF_W(COEF_W), .FRAC(FRAC), .STATE_W(STATE_W)) u_bq (
      .clk(clk), .rst(rst), .en(en_vec[s]), .x(x_s),
      .coef(act_flat[s*SEC_W +: SEC_W]), .y(ysec[s])
    );
  end

  always_comb begin
    sum = '0;
    for (int s = 0; s < NSEC; s++) sum = sum + (STATE_W+1)'(ysec[s]);
  end

  dnp_lowpass #(.COEF_W(COEF_W), .FRAC(FRAC), .STATE_W(STATE_W)) u_lp (
    .clk(clk), .rst(rst), .clr(!path_on), .s(sum),
    .k(act_flat[NSEC*SEC_W +: COEF_W]), .z(z_lp)
  );

  dnp_requant #(.STATE_W(STATE_W), .OUT_W(OUT_W), .QSHIFT(QSHIFT)) u_rq (
    .clk(clk), .rst(rst), .clr(!path_on), .z(z_lp), .q(dac_code), .err(err_q)
  );
endmodule

// File: rtl/dnp_checker.sv
module dnp_checker #(
  parameter int FLAT_W  = 99,
  parameter int STATE_W = 18,
  parameter int OUT_W   = 5,
  parameter int QSHIFT  = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      en_tx,
  input logic                      en_bl,
  input logic                      cfg_load,
  input logic [FLAT_W-1:0]         act_flat,
  input logic signed [STATE_W-1:0] y_tx,
  input logic signed [STATE_W-1:0] y_bl,
  input logic signed [STATE_W-1:0] err_q,
  input logic signed [OUT_W-1:0]   dac_code
);
  localparam logic signed [OUT_W-1:0]   QTOP = OUT_W'(2**(OUT_W-1) - 1);
  localparam logic signed [OUT_W-1:0]   QBOT = OUT_W'(-(2**(OUT_W-1)));
  localparam logic signed [STATE_W-1:0] EUP  = STATE_W'(2**QSHIFT);

  AST_PATH_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!en_tx && !en_bl) |=> (dac_code == '0)); // R10
  AST_TX_OFF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !en_tx |=> (y_tx == '0)); // R9
  AST_BL_OFF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !en_bl |=> (y_bl == '0)); // R9
  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(act_flat)); // R6
  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
    (dac_code != QTOP && dac_code != QBOT) |-> (err_q >= 0 && err_q < EUP)); // R8
endmodule

bind dual_notch_path dnp_checker #(
  .FLAT_W(dnp_pkg::NREG * COEF_W), .STATE_W(STATE_W), .OUT_W(OUT_W), .QSHIFT(QSHIFT)
) u_chk (
  .clk(clk), .rst(rst), .en_tx(en_tx), .en_bl(en_bl), .cfg_load(cfg_load),
  .act_flat(act_flat), .y_tx(ysec[0]), .y_bl(ysec[1]), .err_q(err_q),
  .dac_code(dac_code)
);

// File: tb/tb_dual_notch_path.sv
`timescale 1ns/1ps
module tb_dual_notch_path;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [4:0]        code_in = 5'd8;
  logic              en_tx = 1'b0, en_bl = 1'b0;
  logic              cfg_we = 1'b0, cfg_load = 1'b0;
  logic [3:0]        cfg_addr = '0;
  logic [8:0]        cfg_data = '0;
  logic signed [4:0] dac_code;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_notch_path dut (
    .clk(clk), .rst(rst), .code_in(code_in), .en_tx(en_tx), .en_bl(en_bl),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cfg_load(cfg_load), .dac_code(dac_code)
  );

  // ---------------- reference model built from the requirements ----------------
  localparam longint SMX = 131071, SMN = -131072;
  longint stg [11], act [11];
  longint mx1 [2], mx2 [2], my1 [2], my2 [2];
  longint mz, me, mq;

  function automatic longint clampv(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  always @(posedge clk) begin
    longint x, acc, ny [2], s, nz, w, q, ne;
    bit en [2];
    if (rst) begin
      for (int i = 0; i < 11; i++) begin stg[i] = 0; act[i] = 0; end
      for (int i = 0; i < 2; i++) begin mx1[i] = 0; mx2[i] = 0; my1[i] = 0; my2[i] = 0; end
      mz = 0; me = 0; mq = 0;
    end else begin
      en[0] = en_tx; en[1] = en_bl;
      x = longint'(code_in) - 8;                                  // R2
      for (int sct = 0; sct < 2; sct++) begin
        acc = act[sct*5] * x + act[sct*5+1] * mx1[sct] + act[sct*5+2] * mx2[sct]
            - act[sct*5+3] * my1[sct] - act[sct*5+4] * my2[sct];
        ny[sct] = clampv(acc >>> 7, SMN, SMX);                     // R3
      end
      s  = my1[0] + my1[1];                                        // R4
      nz = clampv(s + ((act[10] * mz) >>> 7), SMN, SMX);           // R7
      w  = mz + me;
      q  = clampv(w >>> 2, -16, 15);                               // R8
      ne = clampv(w - q * 4, SMN, SMX);
      for (int sct = 0; sct < 2; sct++) begin
        if (!en[sct]) begin mx1[sct] = 0; mx2[sct] = 0; my1[sct] = 0; my2[sct] = 0; end
        else begin mx2[sct] = mx1[sct]; mx1[sct] = x; my2[sct] = my1[sct]; my1[sct] = ny[sct]; end
      end
      if (!en_tx && !en_bl) begin mz = 0; me = 0; mq = 0; end      // R10
      else begin mz = nz; me = ne; mq = q; end
      if (cfg_load) for (int i = 0; i < 11; i++) act[i] = stg[i];  // R6
      if (cfg_we && cfg_addr < 11) stg[cfg_addr] = longint'($signed(cfg_data)); // R5
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(int actv, int expv, string tag);
    n_cmp++;
    if (actv != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, actv, expv);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    @(negedge clk);
    chk(int'(dac_code), int'(mq), tag);
  endtask

  task automatic wr(int a, int v);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_data = 9'(v);
    cyc("R5 write");
    cfg_we = 1'b0;
  endtask

  task automatic ld();
    cfg_load = 1'b1;
    cyc("R6 load");
    cfg_load = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // stimulus table: {en_tx, en_bl, code}
  localparam logic [6:0] VEC [0:23] = '{
    {2'b11, 5'd16}, {2'b11, 5'd0},  {2'b11, 5'd16}, {2'b11, 5'd0},
    {2'b11, 5'd12}, {2'b11, 5'd4},  {2'b11, 5'd9},  {2'b11, 5'd7},
    {2'b10, 5'd16}, {2'b10, 5'd16}, {2'b10, 5'd0},  {2'b10, 5'd8},
    {2'b01, 5'd1},  {2'b01, 5'd15}, {2'b01, 5'd2},  {2'b01, 5'd14},
    {2'b11, 5'd3},  {2'b11, 5'd5},  {2'b11, 5'd11}, {2'b11, 5'd13},
    {2'b00, 5'd16}, {2'b11, 5'd16}, {2'b11, 5'd8},  {2'b11, 5'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(int'(dac_code), 0, "R1 reset output");
    // R1: zero coefficients keep output at zero even when enabled
    en_tx = 1; en_bl = 1; code_in = 5'd16;
    repeat (4) cyc("R1");
    chk(int'(dac_code), 0, "R1 zero coefs");
    en_tx = 0; en_bl = 0; code_in = 5'd8;

    // R11 / R8: impulse through pass-through sections
    wr(0, 255); wr(5, 255); ld();
    en_tx = 1; en_bl = 1; code_in = 5'd16;
    cyc("R11");
    chk(int'(dac_code), 0, "R11 edge n");
    code_in = 5'd8;
    cyc("R11");
    chk(int'(dac_code), 0, "R11 edge n+1");
    cyc("R11");
    chk(int'(dac_code), 7, "R11 R8 edge n+2");
    cyc("R8");
    chk(int'(dac_code), 0, "R8 residual error");
    en_tx = 0; en_bl = 0;
    cyc("R10");

    // main patterns with resonant sections and lowpass
    wr(0, 64); wr(1, 0); wr(2, -64); wr(3, -90); wr(4, 100);
    wr(5, 40); wr(6, 0); wr(7, -40); wr(8, 60); wr(9, 110);
    wr(10, 96); ld();
    for (int i = 0; i < 24; i++) begin
      en_tx = VEC[i][6]; en_bl = VEC[i][5]; code_in = VEC[i][4:0];
      cyc((VEC[i][6:5] == 2'b11) ? "R4 dual" : ((VEC[i][6:5] == 2'b00) ? "R10 off" : "R3 single"));
    end
    en_tx = 0; en_bl = 0; code_in = 5'd16;
    cyc("R10");
    chk(int'(dac_code), 0, "R10 both off");

    // R9: toggle one section while the other keeps the path on
    en_tx = 1; en_bl = 1;
    repeat (6) cyc("R9 build");
    en_tx = 0; code_in = 5'd8;
    cyc("R9 off");
    en_tx = 1;
    repeat (8) cyc("R9 restart");

    // R6: staged writes without load have no effect; R5: unused addresses ignored
    wr(0, 255); wr(3, -128); wr(12, 255); wr(15, -1);
    code_in = 5'd16;
    repeat (6) cyc("R6 no load");
    cfg_load = 1'b1; cfg_we = 1'b1; cfg_addr = 4'd10; cfg_data = 9'd127;
    cyc("R6 load with write");
    cfg_load = 1'b0; cfg_we = 1'b0;
    repeat (6) cyc("R5 unused addr");

    // R3: integrator driven into 18-bit clamp
    en_tx = 0; en_bl = 0;
    cyc("R10");
    wr(0, 255); wr(1, 0); wr(2, 0); wr(3, -128); wr(4, 0); wr(10, 0); ld();
    en_tx = 1; code_in = 5'd16;
    repeat (9000) cyc("R3 saturate");
    chk(int'(dac_code), 15, "R3 R8 top rail");
    code_in = 5'd8;
    repeat (200) cyc("R3 hold");
    chk(int'(dac_code), 15, "R3 clamped state");

    // R8: bottom rail through lowpass accumulation
    en_tx = 0;
    cyc("R10");
    wr(3, 0); wr(10, 120); ld();
    en_tx = 1; code_in = 5'd0;
    repeat (100) cyc("R7 R8");
    chk(int'(dac_code), -16, "R8 bottom rail");
    finish_run();
  end
endmodule